// File: doc/BRIEF.md
# Fixed-Point Register Operation Unit

This unit executes four fixed-point operations on 32-bit general-register values: an add with a sign-extended 16-bit immediate, a two's complement negate, a signed compare, and a logical left shift of a 64-bit even/odd register pair. A sequencer hands it operands that have already been read from the register file, with one request per cycle. One clock later the unit returns the result words, a 2-bit condition code and a valid strobe. The caller writes the result back and keeps the condition code.

Every output is a register. The outputs change only on a cycle after a request and hold their values between requests. The shift takes its amount from the low six bits of a 12-bit computed address field and ignores the upper bits. A shift whose pair starts at an odd register number returns a specification error in place of a result.

Top module: `fxp_reg_unit`

## Requirements
- R1: Operation codes on `req_op` are 0 halfword add, 1 load complement, 2 compare and 3 double shift. Each cycle with `req_valid` high gives `res_valid` high in the next cycle. Each cycle with `req_valid` low gives `res_valid` low in the next cycle, and `res_hi`, `res_lo`, `cond_code` and `spec_err` keep their values.
- R2: Halfword add returns `res_lo` = `opnd_a` + the sign extension of `half_imm`, modulo 2^32, with `res_hi` = 0.
- R3: Load complement returns `res_lo` = the two's complement of `opnd_b`, with `res_hi` = 0. `opnd_a` has no effect.
- R4: Add and load complement set `cond_code` to 3 on signed overflow. Without overflow they set it to 0 for a zero result, 1 for a negative result and 2 for a positive result. Complementing 0x80000000 returns 0x80000000 with code 3.
- R5: Compare treats `opnd_a` and `opnd_b` as signed. It sets `cond_code` to 0 when they are equal, 1 when `opnd_a` is less and 2 when `opnd_a` is greater, and it returns zero on both result words.
- R6: The double shift returns {`res_hi`,`res_lo`} = {`opnd_a`,`opnd_b`} shifted left by `shift_field[5:0]`, filling with zeros. `shift_field[11:6]` is ignored, and an amount of 0 returns the pair unchanged.
- R7: A double shift leaves `cond_code` at its previous value.
- R8: A double shift with `pair_reg[0]` = 1 gives `spec_err` = 1, zero result words and an unchanged `cond_code`. Every other valid request gives `spec_err` = 0, and `pair_reg` has no effect on the other operations.
- R9: While `rst_n` is low at a clock edge, all outputs clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code |
| opnd_a | input | 32 | First operand; high word of the shift pair |
| opnd_b | input | 32 | Second operand; low word of the shift pair |
| half_imm | input | 16 | Signed halfword for the add |
| shift_field | input | 12 | Computed address field; low 6 bits give the shift amount |
| pair_reg | input | 4 | Register number of the first register of the shift pair |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_hi | output | 32 | High result word (shift only) |
| res_lo | output | 32 | Result word |
| cond_code | output | 2 | Condition code |
| spec_err | output | 1 | Odd-pair specification error |

## Verification
The add is driven with random operands and immediates of both signs. Directed sums at the signed limits separate the overflow code from the sign codes, and a wrap to zero separates the zero code from overflow. The negate is tried on 0, on 0x80000000 and on random values, which tells the overflow case apart from ordinary sign flips. Compare pairs include equal values and operands with opposite signs, which a correct signed compare and an unsigned one order differently. Shifts use amounts 0, 1, 31, 32 and 63 with junk in the upper field bits, and odd pair numbers placed between operations that set the code, so a lost or overwritten condition code shows up.

// File: rtl/fxp_pkg.sv
// Package: shared widths and operation codes for the fixed-point register unit.
// Assumes two's complement 32-bit words and a 64-bit even/odd register pair.
package fxp_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int FIELD_W = 12;
    localparam int REG_W   = 4;

    typedef enum logic [1:0] {
        OP_ADDH  = 2'd0,
        OP_LCOMP = 2'd1,
        OP_CMP   = 2'd2,
        OP_SLDL  = 2'd3
    } fxp_op_e;

    // Condition-code values used by the arithmetic and compare paths.
    localparam logic [1:0] CC_ZERO_EQ = 2'd0;
    localparam logic [1:0] CC_NEG_LT  = 2'd1;
    localparam logic [1:0] CC_POS_GT  = 2'd2;
    localparam logic [1:0] CC_OVF     = 2'd3;
endpackage

// File: rtl/fxp_arith.sv
// Module: fxp_arith
// Computes either first operand + sign-extended halfword or 0 - second operand
// through a single adder, and derives the zero/negative/positive/overflow code.
// Assumes HALF_W <= W. Purely combinational.
module fxp_arith #(
    parameter int W      = 32,
    parameter int HALF_W = 16
) (
    input  logic              negate,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [HALF_W-1:0] half_imm,
    output logic [W-1:0]      sum,
    output logic [1:0]        cc
);
    import fxp_pkg::*;

    localparam int EXT_W = W - HALF_W;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] x_in;
    logic [W-1:0] y_in;
    logic         c_in;
    logic         ovf;

    // Select adder inputs: add uses the extended halfword, negate uses ~b + 1.
    always_comb begin
        if (negate) begin
            x_in = '0;
            y_in = ~opnd_b;
            c_in = 1'b1;
        end else begin
            x_in = opnd_a;
            y_in = {{EXT_W{half_imm[HALF_W-1]}}, half_imm};
            c_in = 1'b0;
        end
    end

    // Single adder shared by both operations.
    assign sum = x_in + y_in + {{(W-1){1'b0}}, c_in};

    // Signed overflow when both inputs agree in sign and the sum does not.
    assign ovf = (x_in[W-1] == y_in[W-1]) && (sum[W-1] != x_in[W-1]);

    // Map the result to a condition code, overflow taking priority.
    always_comb begin
        if (ovf)              cc = CC_OVF;
        else if (sum == '0)   cc = CC_ZERO_EQ;
        else if (sum[W-1])    cc = CC_NEG_LT;
        else                  cc = CC_POS_GT;
    end

    // Negating the most negative word must report overflow.
    always_comb begin
        if (negate && opnd_b == MIN_NEG)
            AST_MIN_NEGATE_OVF: assert (cc == CC_OVF); // R4
    end
endmodule

// File: rtl/fxp_compare.sv
// Module: fxp_compare
// Signed comparison of two words producing the equal/less/greater code.
// Assumes both operands are two's complement. Purely combinational.
module fxp_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [1:0]   cc
);
    import fxp_pkg::*;

    logic a_lt_b;
    logic a_eq_b;

    // Sign-aware ordering and equality of the two operands.
    assign a_lt_b = $signed(opnd_a) < $signed(opnd_b);
    assign a_eq_b = (opnd_a == opnd_b);

    // Encode the ordering into the condition code.
    always_comb begin
        if (a_eq_b)      cc = CC_ZERO_EQ;
        else if (a_lt_b) cc = CC_NEG_LT;
        else             cc = CC_POS_GT;
    end

    // A negative first operand against a non-negative second is always less.
    always_comb begin
        if (opnd_a[W-1] && !opnd_b[W-1])
            AST_SIGNED_ORDER: assert (cc == CC_NEG_LT); // R5
    end
endmodule

// File: rtl/fxp_dshift.sv
// Module: fxp_dshift
// Logical left shift of a two-word register pair by an amount taken from the
// low bits of a wider address field; upper field bits are discarded.
// Assumes FIELD_W >= $clog2(2*W). Purely combinational.
module fxp_dshift #(
    parameter int W       = 32,
    parameter int FIELD_W = 12
) (
    input  logic [W-1:0]       word_hi,
    input  logic [W-1:0]       word_lo,
    input  logic [FIELD_W-1:0] shift_field,
    output logic [W-1:0]       out_hi,
    output logic [W-1:0]       out_lo
);
    localparam int PAIR_W = 2 * W;
    localparam int AMT_W  = $clog2(PAIR_W);

    logic [AMT_W-1:0]  amount;
    logic [PAIR_W-1:0] pair_in;
    logic [PAIR_W-1:0] pair_out;

    // Keep only the low bits of the field as the shift count.
    assign amount  = shift_field[AMT_W-1:0];
    assign pair_in = {word_hi, word_lo};

    // Zero-filling left shift of the concatenated pair.
    assign pair_out = pair_in << amount;
    assign out_hi   = pair_out[PAIR_W-1:W];
    assign out_lo   = pair_out[W-1:0];

    // A zero amount passes the pair through untouched.
    always_comb begin
        if (amount == '0)
            AST_ZERO_SHIFT_IDENT: assert ({out_hi, out_lo} == pair_in); // R6
    end
endmodule

// File: rtl/fxp_reg_unit.sv
// Module: fxp_reg_unit (top)
// Executes halfword add, load complement, signed compare and double-register
// shift on operands supplied by the caller; result words, condition code and
// error flag are registered and change only one cycle after a valid request.
// Assumes register-file reads and write-back are handled outside.
module fxp_reg_unit #(
    parameter int W       = fxp_pkg::WORD_W,
    parameter int HALF_W  = fxp_pkg::HALF_W,
    parameter int FIELD_W = fxp_pkg::FIELD_W,
    parameter int REG_W   = fxp_pkg::REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [W-1:0]       opnd_a,
    input  logic [W-1:0]       opnd_b,
    input  logic [HALF_W-1:0]  half_imm,
    input  logic [FIELD_W-1:0] shift_field,
    input  logic [REG_W-1:0]   pair_reg,
    output logic               res_valid,
    output logic [W-1:0]       res_hi,
    output logic [W-1:0]       res_lo,
    output logic [1:0]         cond_code,
    output logic               spec_err
);
    import fxp_pkg::*;

    fxp_op_e      op;
    logic [W-1:0] arith_sum;
    logic [1:0]   arith_cc;
    logic [1:0]   cmp_cc;
    logic [W-1:0] sh_hi;
    logic [W-1:0] sh_lo;
    logic         odd_pair;

    logic [W-1:0] nxt_hi;
    logic [W-1:0] nxt_lo;
    logic [1:0]   nxt_cc;
    logic         nxt_err;

    assign op       = fxp_op_e'(req_op);
    assign odd_pair = pair_reg[0];

    fxp_arith #(.W(W), .HALF_W(HALF_W)) u_arith (
        .negate   (op == OP_LCOMP),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .half_imm (half_imm),
        .sum      (arith_sum),
        .cc       (arith_cc)
    );

    fxp_compare #(.W(W)) u_cmp (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .cc     (cmp_cc)
    );

    fxp_dshift #(.W(W), .FIELD_W(FIELD_W)) u_shift (
        .word_hi     (opnd_a),
        .word_lo     (opnd_b),
        .shift_field (shift_field),
        .out_hi      (sh_hi),
        .out_lo      (sh_lo)
    );

    // Choose the next result, code and error flag for the requested operation.
    always_comb begin
        nxt_hi  = '0;
        nxt_lo  = '0;
        nxt_cc  = cond_code;
        nxt_err = 1'b0;
        unique case (op)
            OP_ADDH, OP_LCOMP: begin
                nxt_lo = arith_sum;
                nxt_cc = arith_cc;
            end
            OP_CMP: begin
                nxt_cc = cmp_cc;
            end
            OP_SLDL: begin
                if (odd_pair) begin
                    nxt_err = 1'b1;
                end else begin
                    nxt_hi = sh_hi;
                    nxt_lo = sh_lo;
                end
            end
            default: ;
        endcase
    end

    // Output registers: clear on reset, load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hi    <= '0;
            res_lo    <= '0;
            cond_code <= 2'd0;
            spec_err  <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_hi    <= nxt_hi;
                res_lo    <= nxt_lo;
                cond_code <= nxt_cc;
                spec_err  <= nxt_err;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> res_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !res_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> ($stable(res_hi) && $stable(res_lo) && $stable(cond_code) && $stable(spec_err))); // R1
    AST_CMP_CC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op == OP_CMP) |=> (cond_code != CC_OVF && res_hi == '0 && res_lo == '0)); // R5
    AST_SHIFT_CC_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op == OP_SLDL) |=> $stable(cond_code)); // R7
    AST_ODD_PAIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op == OP_SLDL && pair_reg[0]) |=> (spec_err && res_hi == '0 && res_lo == '0)); // R8
    AST_NO_FLAG_ELSE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !(req_op == OP_SLDL && pair_reg[0])) |=> !spec_err); // R8
    AST_ARITH_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && (req_op == OP_ADDH || req_op == OP_LCOMP)) |=> res_hi == '0); // R2
endmodule

// File: tb/fxp_reg_unit_tb.sv
module fxp_reg_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] half_imm = '0;
    logic [11:0] shift_field = '0;
    logic [3:0]  pair_reg = '0;
    logic        res_valid;
    logic [31:0] res_hi;
    logic [31:0] res_lo;
    logic [1:0]  cond_code;
    logic        spec_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state kept by the bench.
    logic [31:0] e_hi = '0;
    logic [31:0] e_lo = '0;
    logic [1:0]  e_cc = 2'd0;
    logic        e_err = 1'b0;

    always #10 clk = ~clk;

    fxp_reg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .half_imm(half_imm),
        .shift_field(shift_field), .pair_reg(pair_reg),
        .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo),
        .cond_code(cond_code), .spec_err(spec_err)
    );

    function automatic logic [1:0] arith_code(longint exact, logic [31:0] r);
        if (exact > 64'sd2147483647 || exact < -64'sd2147483648) return 2'd3;
        if (r == 32'd0) return 2'd0;
        if (exact < 0) return 2'd1;
        return 2'd2;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compute the reference outcome of one request.
    task automatic model(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                         logic [15:0] h, logic [11:0] f, logic [3:0] pr);
        longint exact;
        logic [63:0] p;
        e_err = 1'b0;
        e_hi  = '0;
        e_lo  = '0;
        case (op)
            2'd0: begin
                exact = longint'($signed(a)) + longint'($signed(h));
                e_lo  = exact[31:0];
                e_cc  = arith_code(exact, e_lo);
            end
            2'd1: begin
                exact = -longint'($signed(b));
                e_lo  = exact[31:0];
                e_cc  = arith_code(exact, e_lo);
            end
            2'd2: begin
                if (a == b) e_cc = 2'd0;
                else if ($signed(a) < $signed(b)) e_cc = 2'd1;
                else e_cc = 2'd2;
            end
            default: begin
                if (pr[0]) e_err = 1'b1;
                else begin
                    p = {a, b};
                    for (int i = 0; i < 64; i++) if (i < int'(f[5:0])) p = {p[62:0], 1'b0};
                    e_hi = p[63:32];
                    e_lo = p[31:0];
                end
            end
        endcase
    endtask

    // Issue one request, then compare all outputs in the following cycle.
    task automatic req(string tag, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] h, logic [11:0] f, logic [3:0] pr);
        req_valid = 1'b1; req_op = op; opnd_a = a; opnd_b = b;
        half_imm = h; shift_field = f; pair_reg = pr;
        model(op, a, b, h, f, pr);
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "valid", {63'd0, res_valid}, 64'd1);
        chk(tag, "result", {res_hi, res_lo}, {e_hi, e_lo});
        chk(tag, "cc", {62'd0, cond_code}, {62'd0, e_cc});
        chk(tag, "spec_err", {63'd0, spec_err}, {63'd0, e_err});
    endtask

    // One idle cycle with scrambled inputs: nothing may move.
    task automatic idle();
        opnd_a = $urandom; opnd_b = $urandom; req_op = 2'($urandom);
        @(negedge clk);
        chk("R1", "idle valid", {63'd0, res_valid}, 64'd0);
        chk("R1", "idle hold", {res_hi, res_lo}, {e_hi, e_lo});
        chk("R1", "idle cc", {62'd0, cond_code}, {62'd0, e_cc});
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        opnd_a = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset valid", {63'd0, res_valid}, 64'd0);
        chk("R9", "reset result", {res_hi, res_lo}, 64'd0);
        chk("R9", "reset cc", {62'd0, cond_code}, 64'd0);
        chk("R9", "reset err", {63'd0, spec_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4 directed add corners
        req("R2", 2'd0, 32'd10, 32'd0, 16'hFFF6, 12'd0, 4'd0);        // zero
        req("R4", 2'd0, 32'h7FFF_FFFF, 32'd0, 16'h0001, 12'd0, 4'd1); // overflow
        req("R4", 2'd0, 32'h8000_0000, 32'd0, 16'hFFFF, 12'd0, 4'd0); // negative overflow
        req("R2", 2'd0, 32'd5, 32'd0, 16'h8000, 12'd0, 4'd0);         // negative
        idle();
        // R3/R4 complement corners
        req("R4", 2'd1, 32'h1234, 32'h8000_0000, 16'd0, 12'd0, 4'd0);
        req("R3", 2'd1, 32'hFFFF, 32'd0, 16'd0, 12'd0, 4'd3);
        req("R3", 2'd1, 32'd0, 32'hFFFF_FFFF, 16'd0, 12'd0, 4'd0);
        // R5 compare with opposite signs
        req("R5", 2'd2, 32'hFFFF_FFFF, 32'd1, 16'd0, 12'd0, 4'd0);
        req("R5", 2'd2, 32'd1, 32'hFFFF_FFFF, 16'd0, 12'd0, 4'd0);
        req("R5", 2'd2, 32'h8000_0000, 32'h8000_0000, 16'd0, 12'd0, 4'd0);
        // R6/R7 shifts, upper field bits set, code must survive
        req("R4", 2'd1, 32'd0, 32'd7, 16'd0, 12'd0, 4'd0); // sets cc=1
        req("R6", 2'd3, 32'h0123_4567, 32'h89AB_CDEF, 16'd0, 12'hFC0, 4'd2);
        req("R7", 2'd3, 32'h0123_4567, 32'h89AB_CDEF, 16'd0, 12'h041, 4'd4);
        req("R6", 2'd3, 32'h0123_4567, 32'h89AB_CDEF, 16'd0, 12'h01F, 4'd0);
        req("R6", 2'd3, 32'h0123_4567, 32'h89AB_CDEF, 16'd0, 12'h020, 4'd6);
        req("R6", 2'd3, 32'h0123_4567, 32'h89AB_CDEF, 16'd0, 12'hABF, 4'd8);
        // R8 odd pair, then a normal op clears the flag
        req("R8", 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, 12'd4, 4'd7);
        idle();
        req("R8", 2'd2, 32'd3, 32'd3, 16'd0, 12'd0, 4'd9);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            req("R1", 2'($urandom), $urandom, $urandom, 16'($urandom),
                12'($urandom), 4'($urandom));
            if ($urandom % 4 == 0) idle();
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule